// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End with Squash

This block is the front end of a two-stage processor core whose second stage decodes, executes and writes back in a single cycle. It holds the fetch program counter and presents it to an external instruction memory every cycle. The memory answers within the same cycle, and the returned word is captured, together with the address it came from, in the register that feeds the execute stage.

The block never computes branch or jump targets. The execute stage raises a redirect request with a target address whenever it holds a jump or a taken branch. On that edge the program counter loads the target, and the word fetched in that cycle is discarded: the all-zero word, which the core treats as a no-operation, is multiplexed in ahead of the register. Execute therefore never sees a wrong-path instruction, and no delay slot is exposed to software. A branch that is not taken simply leaves the request low. The clock is never gated. Every state change happens on the edge through multiplexers.

Top module: `fetch_front`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fetch_addr` is 0, `ex_instr` is 0x00000000 and `ex_pc` is 0. The first execute cycle therefore runs a no-operation.
- R2: On a rising edge with `redir_valid` low, `fetch_addr` advances by 4, wrapping modulo 2^32 (0xFFFFFFFC is followed by 0x00000000).
- R3: On a rising edge with `redir_valid` high, `fetch_addr` takes the value of `redir_target`.
- R4: On a rising edge with `redir_valid` low, `ex_instr` takes the value `fetch_instr` held in the cycle before the edge.
- R5: On a rising edge with `redir_valid` high, `ex_instr` becomes 0x00000000. This holds for every cycle of back-to-back or held redirects.
- R6: After every rising edge out of reset, `ex_pc` equals the `fetch_addr` of the cycle before the edge. This includes squashed slots.
- R7: `fetch_addr` is a registered value. Changing `redir_valid` or `redir_target` within a cycle does not change it before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, never gated |
| rst | input | 1 | Synchronous reset, active high |
| redir_valid | input | 1 | Execute holds a jump or taken branch; squash and redirect |
| redir_target | input | 32 | Address to fetch next when `redir_valid` is high |
| fetch_addr | output | 32 | Address presented to instruction memory |
| fetch_instr | input | 32 | Word returned by instruction memory for `fetch_addr` |
| ex_instr | output | 32 | Instruction handed to the execute stage |
| ex_pc | output | 32 | Address that `ex_instr`'s slot was fetched from |

## Verification
The hardest situations to reach are a redirect in the very next cycle after another redirect, and a redirect held high across several edges. In both, every slot must be squashed while the program counter keeps reloading, so a design that only squashes on a rising request would pass single-redirect tests. The stimulus table places two redirects in consecutive cycles. A directed test then holds the request high for several edges with a fixed target. A further directed case steers the counter to the last word of the address space to expose the wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    parameter int unsigned XLEN = 32;
    parameter int unsigned ILEN = 32;

    localparam int unsigned PC_STEP = ILEN / 8;

    typedef logic [XLEN-1:0] addr_t;
    typedef logic [ILEN-1:0] word_t;

    localparam word_t NOP_WORD = '0;

    // One slot of the fetch-to-execute pipeline register
    typedef struct packed {
        word_t instr;
        addr_t pc;
    } slot_t;

    // Sequential successor of a fetch address (wraps naturally)
    function automatic addr_t seq_next(input addr_t cur);
        return cur + addr_t'(PC_STEP);
    endfunction

    // Word entering execute: squash replaces the fetched word with a nop
    function automatic word_t squash_mux(input logic squash, input word_t fetched);
        return squash ? NOP_WORD : fetched;
    endfunction

endpackage

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  redir_valid,
    input  addr_t redir_target,
    output addr_t pc_q
);

    addr_t pc_d;

    always_comb begin
        if (redir_valid) begin
            pc_d = redir_target;
        end else begin
            pc_d = seq_next(pc_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/fetch_slot_reg.sv
module fetch_slot_reg
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  squash,
    input  word_t fetched_word,
    input  addr_t fetched_pc,
    output slot_t slot_q
);

    slot_t slot_d;

    always_comb begin
        slot_d.instr = squash_mux(squash, fetched_word);
        slot_d.pc    = fetched_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{instr: NOP_WORD, pc: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/fetch_front.sv
module fetch_front
    import fetch_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        redir_valid,
    input  logic [31:0] redir_target,
    output logic [31:0] fetch_addr,
    input  logic [31:0] fetch_instr,
    output logic [31:0] ex_instr,
    output logic [31:0] ex_pc
);

    addr_t pc_q;
    slot_t slot_q;

    fetch_pc_unit #(
        .RESET_PC (addr_t'(RESET_PC))
    ) pc_i (
        .clk          (clk),
        .rst          (rst),
        .redir_valid  (redir_valid),
        .redir_target (addr_t'(redir_target)),
        .pc_q         (pc_q)
    );

    fetch_slot_reg slot_i (
        .clk          (clk),
        .rst          (rst),
        .squash       (redir_valid),
        .fetched_word (word_t'(fetch_instr)),
        .fetched_pc   (pc_q),
        .slot_q       (slot_q)
    );

    assign fetch_addr = 32'(pc_q);
    assign ex_instr   = 32'(slot_q.instr);
    assign ex_pc      = 32'(slot_q.pc);

endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        redir_valid,
    input logic [31:0] redir_target,
    input logic [31:0] fetch_addr,
    input logic [31:0] fetch_instr,
    input logic [31:0] ex_instr,
    input logic [31:0] ex_pc
);

    logic seen_edge;

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    // R1: state right after a reset edge
    assert_reset_state_R1: assert property (@(posedge clk)
        (seen_edge && $past(rst)) |-> (fetch_addr == 32'h0 && ex_instr == 32'h0 && ex_pc == 32'h0));

    // R2
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |=> fetch_addr == $past(fetch_addr) + 32'd4);

    // R3
    assert_redirect_load_R3: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> fetch_addr == $past(redir_target));

    // R4
    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |=> ex_instr == $past(fetch_instr));

    // R5
    assert_squash_nop_R5: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> ex_instr == 32'h0);

    // R6
    assert_pc_pairing_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ex_pc == $past(fetch_addr));

endmodule

bind fetch_front fetch_front_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .fetch_addr   (fetch_addr),
    .fetch_instr  (fetch_instr),
    .ex_instr     (ex_instr),
    .ex_pc        (ex_pc)
);

// File: tb/fetch_front_tb.sv
module fetch_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_target = 32'h0;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_instr;
    logic [31:0] ex_instr;
    logic [31:0] ex_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    // Instruction memory model: never returns the all-zero word
    function automatic logic [31:0] imem(input logic [31:0] a);
        return {8'hA5, a[23:0]};
    endfunction

    assign fetch_instr = imem(fetch_addr);

    fetch_front dut_i (
        .clk          (clk),
        .rst          (rst),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .fetch_addr   (fetch_addr),
        .fetch_instr  (fetch_instr),
        .ex_instr     (ex_instr),
        .ex_pc        (ex_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of redirect inputs; sample after the edge at the next negedge
    task automatic step(input logic rv, input logic [31:0] tgt,
                        output logic [31:0] fa, output logic [31:0] ei,
                        output logic [31:0] ep);
        redir_valid  = rv;
        redir_target = tgt;
        @(negedge clk);
        fa = fetch_addr;
        ei = ex_instr;
        ep = ex_pc;
    endtask

    // Stimulus table: redirect, target, expected fetch addr, squashed?, expected ex_pc
    localparam int NV = 8;
    localparam logic        V_RV  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] V_TGT [NV] = '{32'h0, 32'h0, 32'h100, 32'h0, 32'h40, 32'h80, 32'h0, 32'h0};
    localparam logic [31:0] V_FA  [NV] = '{32'h4, 32'h8, 32'h100, 32'h104, 32'h40, 32'h80, 32'h84, 32'h88};
    localparam logic        V_SQ  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] V_PC  [NV] = '{32'h0, 32'h4, 32'h8, 32'h100, 32'h104, 32'h40, 32'h80, 32'h84};

    initial begin
        logic [31:0] fa, ei, ep;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        check("R1", "fetch_addr in reset", fetch_addr, 32'h0);
        check("R1", "ex_instr in reset", ex_instr, 32'h0);
        check("R1", "ex_pc in reset", ex_pc, 32'h0);
        rst = 1'b0;
        check("R1", "fetch_addr first cycle", fetch_addr, 32'h0);
        check("R1", "ex_instr first cycle nop", ex_instr, 32'h0);

        // Table walk (R2..R6)
        for (int i = 0; i < NV; i++) begin
            step(V_RV[i], V_TGT[i], fa, ei, ep);
            check(V_RV[i] ? "R3" : "R2", $sformatf("table %0d fetch_addr", i), fa, V_FA[i]);
            check(V_SQ[i] ? "R5" : "R4", $sformatf("table %0d ex_instr", i), ei,
                  V_SQ[i] ? 32'h0 : imem(V_PC[i]));
            check("R6", $sformatf("table %0d ex_pc", i), ep, V_PC[i]);
        end

        // R7: mid-cycle redirect change leaves fetch_addr alone until the edge
        redir_valid  = 1'b1;
        redir_target = 32'h0000_0800;
        #1;
        check("R7", "fetch_addr before edge", fetch_addr, 32'h88);
        redir_target = 32'h0000_0900;
        #0.5;
        check("R7", "fetch_addr after target change", fetch_addr, 32'h88);
        @(negedge clk);
        check("R3", "redirect after mid-cycle change", fetch_addr, 32'h900);

        // R5: redirect held across several edges with a fixed target
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 32'h0000_0200, fa, ei, ep);
            check("R3", $sformatf("held redirect %0d fetch_addr", k), fa, 32'h200);
            check("R5", $sformatf("held redirect %0d ex_instr", k), ei, 32'h0);
        end
        step(1'b0, 32'h0, fa, ei, ep);
        check("R4", "after held redirect ex_instr", ei, imem(32'h200));
        check("R6", "after held redirect ex_pc", ep, 32'h200);

        // R2: wrap at top of address space
        step(1'b1, 32'hFFFF_FFFC, fa, ei, ep);
        check("R3", "redirect to last word", fa, 32'hFFFF_FFFC);
        step(1'b0, 32'h0, fa, ei, ep);
        check("R2", "wrap to zero", fa, 32'h0);
        check("R6", "ex_pc of last word", ep, 32'hFFFF_FFFC);
        check("R4", "ex_instr of last word", ei, imem(32'hFFFF_FFFC));

        // R1: reset in the middle of a run
        step(1'b0, 32'h0, fa, ei, ep);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid-run reset fetch_addr", fetch_addr, 32'h0);
        check("R1", "mid-run reset ex_instr", ex_instr, 32'h0);
        check("R1", "mid-run reset ex_pc", ex_pc, 32'h0);
        rst = 1'b0;
        step(1'b0, 32'h0, fa, ei, ep);
        check("R2", "advance after reset", fa, 32'h4);
        check("R4", "first fetched word after reset", ei, imem(32'h0));

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=%08h expected=%08h", 32'h0, 32'h1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule